// File: doc/BRIEF.md
# Bank-Aware Physical Register Allocator

This block sits in the rename stage of an out-of-order core. It tracks which entries of a 160-entry physical register file are live. On request it hands out one free physical index per cycle. In the same cycle it takes back one index that commit has retired, which is the register that held the previous mapping of the overwritten architectural register. The file is divided into equal banks of `BANK_SIZE` registers (4, 8 or 16). A live count for every bank is exported so that power control can gate the banks that hold nothing.

Four placement policies can be chosen at run time:
- **Queue order.** Indices are served in the order in which they became free.
- **Lowest free index.** The lowest-numbered free register is granted.
- **Fullest bank.** The lowest free register in the fullest bank that still has room is granted.
- **Most recent bank.** The lowest free register in the bank of the previous grant is granted.

The last two policies keep live registers packed into as few banks as possible, so more banks stay empty and can be switched off.

Top module: `bank_reg_alloc`

## Requirements
- R1: After reset no register is live, every bank count reads zero, the active policy is queue order, and the first grant is index 0.
- R2: While `alloc_req` is high and at least one register is free, `alloc_vld` is high in the same cycle. `alloc_idx` is then a free index below 160, and it becomes live at the next rising clock edge.
- R3: Policy code 0 (queue order) grants the index at the head of a circular queue. A valid release is appended at the tail. After reset, or after entering this policy, the queue holds 0 to 159 in ascending order.
- R4: Policy code 1 (lowest index) grants the lowest-numbered free register.
- R5: Policy code 2 (fullest bank) grants the lowest free register of the bank with the highest live count below `BANK_SIZE`. Equal counts resolve to the lowest bank number.
- R6: Policy code 3 (recent bank) grants the lowest free register of the bank that held the previous grant (bank 0 after reset). If that bank is full, it uses the fullest-bank choice of R5, which then becomes the remembered bank.
- R7: When every register is live, `alloc_vld` stays low and a request changes no state.
- R8: A release of an index that is not live, or that is 160 or above, is ignored.
- R9: Bank b's live count sits at `bank_occ[b*CW +: CW]`, with CW = clog2(BANK_SIZE+1). It is updated at the clock edge for both the grant and the release of that cycle, so a grant and a release in one cycle are both applied before the next selection.
- R10: `pol_sel` becomes the active policy only at a clock edge where no register is live and `alloc_req` is low. At any other edge a different `pol_sel` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pol_sel | input | 2 | Requested placement policy (0 queue, 1 lowest, 2 fullest bank, 3 recent bank) |
| alloc_req | input | 1 | Rename asks for one destination register |
| alloc_vld | output | 1 | A register is granted this cycle |
| alloc_idx | output | clog2(NUM_REGS) | Granted physical index |
| rel_vld | input | 1 | Commit returns one register |
| rel_idx | input | clog2(NUM_REGS) | Index being returned |
| bank_occ | output | NUM_BANKS*CW | Live count of each bank, bank 0 in the low bits |

## Verification
The grant is combinational. `alloc_vld` and `alloc_idx` answer a request in the same cycle it is driven. The bench therefore drives on the falling edge and compares one nanosecond later, well before the edge that commits the grant.

The live bitvector, the bank counts, the queue and the policy register all change at the following rising edge. Their effect is checked in the next cycle's window: through the `bank_occ` compare and through the index that the next grant returns.

A scoreboard model in the bench advances only after that rising edge. This keeps every expected value aligned with the single register stage inside the block.

// File: rtl/bank_reg_alloc_pkg.sv
package bank_reg_alloc_pkg;

  typedef enum logic [1:0] {
    POL_QUEUE  = 2'd0,
    POL_LOWEST = 2'd1,
    POL_FULL   = 2'd2,
    POL_RECENT = 2'd3
  } pol_e;

endpackage

// File: rtl/bank_reg_alloc_queue.sv
module bank_reg_alloc_queue #(
  parameter int DEPTH = 160,
  parameter int IW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rebuild,
  input  logic          pop,
  input  logic          push,
  input  logic [IW-1:0] push_idx,
  output logic [IW-1:0] head_idx
);

  logic [IW-1:0] slot [DEPTH];
  logic [IW-1:0] rd_ptr;
  logic [IW-1:0] wr_ptr;

  function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= IW'(i);
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else if (rebuild) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= IW'(i);
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else begin
      if (push) begin
        slot[wr_ptr] <= push_idx;
        wr_ptr       <= wrap_inc(wr_ptr);
      end
      if (pop) rd_ptr <= wrap_inc(rd_ptr);
    end
  end

  assign head_idx = slot[rd_ptr];

endmodule

// File: rtl/bank_reg_alloc_occ.sv
module bank_reg_alloc_occ #(
  parameter int NB = 10,
  parameter int CW = 5,
  parameter int BW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_vld,
  input  logic [BW-1:0]    inc_bank,
  input  logic             dec_vld,
  input  logic [BW-1:0]    dec_bank,
  output logic [NB*CW-1:0] occ
);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [CW-1:0] cnt;
    logic          up;
    logic          dn;

    assign up = inc_vld && (inc_bank == BW'(b));
    assign dn = dec_vld && (dec_bank == BW'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (up && !dn)  cnt <= cnt + 1'b1;
      else if (dn && !up)  cnt <= cnt - 1'b1;
    end

    assign occ[b*CW +: CW] = cnt;
  end

endmodule

// File: rtl/bank_reg_alloc_pick.sv
module bank_reg_alloc_pick
  import bank_reg_alloc_pkg::*;
#(
  parameter int N  = 160,
  parameter int BS = 16,
  parameter int NB = 10,
  parameter int CW = 5,
  parameter int IW = 8,
  parameter int BW = 4
) (
  input  logic [N-1:0]     busy,
  input  logic [NB*CW-1:0] occ,
  input  pol_e             pol,
  input  logic [BW-1:0]    last_bank,
  input  logic [IW-1:0]    head_idx,
  output logic [IW-1:0]    pick_idx
);

  logic [CW-1:0] occ_a [NB];

  for (genvar b = 0; b < NB; b++) begin : g_unpack
    assign occ_a[b] = occ[b*CW +: CW];
  end

  function automatic logic [IW-1:0] first_in_bank(input logic [N-1:0] bv,
                                                  input logic [BW-1:0] bk);
    logic [IW-1:0] r;
    logic [IW-1:0] p;
    r = '0;
    for (int k = BS - 1; k >= 0; k--) begin
      p = IW'(int'(bk) * BS + k);
      if (!bv[p]) r = p;
    end
    return r;
  endfunction

  logic [BW-1:0] full_bank;
  logic [CW-1:0] full_cnt;
  logic          full_found;
  logic [IW-1:0] lowest;
  logic [BW-1:0] recent_bank;

  always_comb begin
    full_bank  = '0;
    full_cnt   = '0;
    full_found = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (occ_a[b] < CW'(BS) && (!full_found || occ_a[b] > full_cnt)) begin
        full_found = 1'b1;
        full_bank  = BW'(b);
        full_cnt   = occ_a[b];
      end
    end
  end

  always_comb begin
    lowest = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[IW'(i)]) lowest = IW'(i);
    end
  end

  assign recent_bank = (occ_a[last_bank] < CW'(BS)) ? last_bank : full_bank;

  always_comb begin
    unique case (pol)
      POL_QUEUE:  pick_idx = head_idx;
      POL_LOWEST: pick_idx = lowest;
      POL_FULL:   pick_idx = first_in_bank(busy, full_bank);
      default:    pick_idx = first_in_bank(busy, recent_bank);
    endcase
  end

endmodule

// File: rtl/bank_reg_alloc.sv
module bank_reg_alloc
  import bank_reg_alloc_pkg::*;
#(
  parameter  int NUM_REGS  = 160,
  parameter  int BANK_SIZE = 16,
  localparam int NB        = NUM_REGS / BANK_SIZE,
  localparam int IW        = $clog2(NUM_REGS),
  localparam int CW        = $clog2(BANK_SIZE + 1),
  localparam int BW        = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       pol_sel,
  input  logic             alloc_req,
  output logic             alloc_vld,
  output logic [IW-1:0]    alloc_idx,
  input  logic             rel_vld,
  input  logic [IW-1:0]    rel_idx,
  output logic [NB*CW-1:0] bank_occ
);

  logic [NUM_REGS-1:0] busy;
  pol_e                act_pol;
  logic [BW-1:0]       last_bank;
  logic [IW-1:0]       head_idx;
  logic [IW-1:0]       pick_idx;

  // named internal events
  logic          any_free;
  logic          grant_fire;
  logic          rel_ok;
  logic          pol_load;
  logic          q_rebuild;
  logic [BW-1:0] grant_bank;
  logic [BW-1:0] rel_bank;

  function automatic logic [BW-1:0] bank_of(input logic [IW-1:0] idx);
    return BW'(idx / IW'(BANK_SIZE));
  endfunction

  assign any_free   = ~&busy;
  assign alloc_vld  = alloc_req && any_free;
  assign alloc_idx  = pick_idx;
  assign grant_fire = alloc_vld;
  assign rel_ok     = rel_vld && ({1'b0, rel_idx} < (IW+1)'(NUM_REGS)) && busy[rel_idx];
  assign pol_load   = (busy == '0) && !alloc_req;
  assign q_rebuild  = pol_load && (pol_e'(pol_sel) == POL_QUEUE) && (act_pol != POL_QUEUE);
  assign grant_bank = bank_of(alloc_idx);
  assign rel_bank   = bank_of(rel_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= '0;
      act_pol   <= POL_QUEUE;
      last_bank <= '0;
    end else begin
      if (grant_fire) begin
        busy[alloc_idx] <= 1'b1;
        last_bank       <= grant_bank;
      end
      if (rel_ok) busy[rel_idx] <= 1'b0;
      if (pol_load) act_pol <= pol_e'(pol_sel);
    end
  end

  bank_reg_alloc_queue #(
    .DEPTH (NUM_REGS),
    .IW    (IW)
  ) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .rebuild  (q_rebuild),
    .pop      (grant_fire && act_pol == POL_QUEUE),
    .push     (rel_ok && act_pol == POL_QUEUE),
    .push_idx (rel_idx),
    .head_idx (head_idx)
  );

  bank_reg_alloc_occ #(
    .NB (NB),
    .CW (CW),
    .BW (BW)
  ) u_occ (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_vld  (grant_fire),
    .inc_bank (grant_bank),
    .dec_vld  (rel_ok),
    .dec_bank (rel_bank),
    .occ      (bank_occ)
  );

  bank_reg_alloc_pick #(
    .N  (NUM_REGS),
    .BS (BANK_SIZE),
    .NB (NB),
    .CW (CW),
    .IW (IW),
    .BW (BW)
  ) u_pick (
    .busy      (busy),
    .occ       (bank_occ),
    .pol       (act_pol),
    .last_bank (last_bank),
    .head_idx  (head_idx),
    .pick_idx  (pick_idx)
  );

endmodule

// File: rtl/bank_reg_alloc_chk.sv
module bank_reg_alloc_chk #(
  parameter  int NUM_REGS  = 160,
  parameter  int BANK_SIZE = 16,
  localparam int NB        = NUM_REGS / BANK_SIZE,
  localparam int IW        = $clog2(NUM_REGS),
  localparam int CW        = $clog2(BANK_SIZE + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                alloc_req,
  input logic                alloc_vld,
  input logic [IW-1:0]       alloc_idx,
  input logic                rel_vld,
  input logic [IW-1:0]       rel_idx,
  input logic [NUM_REGS-1:0] busy,
  input logic [1:0]          act_pol,
  input logic [NB*CW-1:0]    bank_occ
);

  // R2
  grant_is_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_vld |-> ((alloc_idx < IW'(NUM_REGS)) && !busy[alloc_idx]));

  // R2
  grant_sets_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_vld && !rel_vld) |=> ($countones(busy) == $past($countones(busy)) + 1));

  // R7
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && (&busy) && !rel_vld) |=> ($stable(bank_occ) && $stable(busy)));

  // R8
  stray_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_vld && !alloc_vld && ((rel_idx >= IW'(NUM_REGS)) || !busy[rel_idx]))
      |=> $stable(busy));

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_vld && !rel_vld) |=> ($stable(busy) && $stable(bank_occ)));

  // R10
  policy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_pol) |-> ($past(busy) == '0 && !$past(alloc_req)));

endmodule

bind bank_reg_alloc bank_reg_alloc_chk #(
  .NUM_REGS  (NUM_REGS),
  .BANK_SIZE (BANK_SIZE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .alloc_req (alloc_req),
  .alloc_vld (alloc_vld),
  .alloc_idx (alloc_idx),
  .rel_vld   (rel_vld),
  .rel_idx   (rel_idx),
  .busy      (busy),
  .act_pol   (act_pol),
  .bank_occ  (bank_occ)
);

// File: tb/sim_bank_reg_alloc.sv
module sim_bank_reg_alloc;

  localparam int N  = 160;
  localparam int BS = 16;
  localparam int NB = N / BS;
  localparam int CW = $clog2(BS + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       pol_sel = 2'd0;
  logic             alloc_req = 1'b0;
  logic             rel_vld = 1'b0;
  logic [7:0]       rel_idx = 8'd0;
  logic             alloc_vld;
  logic [7:0]       alloc_idx;
  logic [NB*CW-1:0] bank_occ;

  always #5 clk = ~clk;

  bank_reg_alloc #(.NUM_REGS(N), .BANK_SIZE(BS)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .pol_sel   (pol_sel),
    .alloc_req (alloc_req),
    .alloc_vld (alloc_vld),
    .alloc_idx (alloc_idx),
    .rel_vld   (rel_vld),
    .rel_idx   (rel_idx),
    .bank_occ  (bank_occ)
  );

  int checks = 0;
  int fails  = 0;
  int psel_drv = 0;

  // reference model
  bit m_busy [N];
  int m_q [$];
  int m_pol  = 0;
  int m_last = 0;

  typedef struct {
    bit    vld;
    int    idx;
    string req;
  } exp_t;
  exp_t exp_q [$];
  event mon_ev;

  function automatic int bank_cnt(int b);
    int c = 0;
    for (int k = 0; k < BS; k++) if (m_busy[b*BS + k]) c++;
    return c;
  endfunction

  function automatic int fullest();
    int best = -1;
    int bc = -1;
    for (int b = 0; b < NB; b++) begin
      int c = bank_cnt(b);
      if (c < BS && c > bc) begin best = b; bc = c; end
    end
    return best;
  endfunction

  function automatic int first_free(int b);
    for (int k = 0; k < BS; k++) if (!m_busy[b*BS + k]) return b*BS + k;
    return -1;
  endfunction

  function automatic int predict();
    int b;
    b = fullest();
    if (b < 0) return -1;
    case (m_pol)
      0: return m_q[0];
      1: begin
        for (int i = 0; i < N; i++) if (!m_busy[i]) return i;
        return -1;
      end
      2: return first_free(b);
      default: return (bank_cnt(m_last) < BS) ? first_free(m_last) : first_free(b);
    endcase
  endfunction

  // monitor: pops the expected grant and compares it with the ports
  always @(mon_ev) begin
    exp_t e;
    e = exp_q.pop_front();
    checks++;
    if (alloc_vld !== e.vld || (e.vld && alloc_idx !== 8'(e.idx))) begin
      fails++;
      $display("FAIL %s grant: actual vld=%0b idx=%0d expected vld=%0b idx=%0d",
               e.req, alloc_vld, alloc_idx, e.vld, e.idx);
    end
  end

  // driver: one cycle of stimulus, expected values, model update after the edge
  task automatic step(input bit req, input bit rv, input int ridx, input string tag);
    int  p;
    bit  gv;
    bit  rok;
    @(negedge clk);
    alloc_req = req;
    rel_vld   = rv;
    rel_idx   = 8'(ridx);
    pol_sel   = 2'(psel_drv);
    #1;
    p  = predict();
    gv = req && (p >= 0);
    exp_q.push_back('{gv, p, tag});
    -> mon_ev;
    checks++;
    for (int b = 0; b < NB; b++) begin
      if (int'(bank_occ[b*CW +: CW]) != bank_cnt(b)) begin
        fails++;
        $display("FAIL R9 (%s) bank %0d count: actual=%0d expected=%0d",
                 tag, b, bank_occ[b*CW +: CW], bank_cnt(b));
        break;
      end
    end
    rok = rv && ridx < N && m_busy[ridx];
    @(posedge clk);
    if (fullest() == 0 && bank_cnt(0) == 0 && !req) begin
      bit empty = 1'b1;
      for (int i = 0; i < N; i++) if (m_busy[i]) empty = 1'b0;
      if (empty) begin
        if (psel_drv == 0 && m_pol != 0) begin
          m_q.delete();
          for (int i = 0; i < N; i++) m_q.push_back(i);
        end
        m_pol = psel_drv;
      end
    end
    if (gv) begin
      m_busy[p] = 1'b1;
      m_last = p / BS;
      if (m_pol == 0) void'(m_q.pop_front());
    end
    if (rok) begin
      m_busy[ridx] = 1'b0;
      if (m_pol == 0) m_q.push_back(ridx);
    end
  endtask

  task automatic release_all(input string tag);
    for (int i = 0; i < N; i++) if (m_busy[i]) step(1'b0, 1'b1, i, tag);
  endtask

  task automatic finish_up();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog (all R): actual=hung expected=finished");
    finish_up();
  end

  initial begin
    for (int i = 0; i < N; i++) m_q.push_back(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: idle after reset, then the first grant is 0
    step(1'b0, 1'b0, 0, "R1");
    step(1'b1, 1'b0, 0, "R1");

    // R3: queue order, releases go to the tail
    repeat (4) step(1'b1, 1'b0, 0, "R3");
    step(1'b0, 1'b1, 2, "R3");
    step(1'b0, 1'b1, 0, "R3");

    // R10: policy request ignored while registers are live
    psel_drv = 1;
    step(1'b0, 1'b0, 0, "R10");
    step(1'b1, 1'b0, 0, "R10");
    psel_drv = 0;

    // R2 / R3: drain the whole queue, 2 and 0 come last
    for (int i = 0; i < N - 4; i++) step(1'b1, 1'b0, 0, "R3");

    // R7: full file
    step(1'b1, 1'b0, 0, "R7");
    step(1'b1, 1'b1, 200, "R7");
    // R8: out-of-range release ignored
    step(1'b0, 1'b1, 200, "R8");
    step(1'b1, 1'b0, 0, "R8");
    release_all("R9");

    // R4: lowest free index
    psel_drv = 1;
    step(1'b0, 1'b0, 0, "R10");
    repeat (6) step(1'b1, 1'b0, 0, "R4");
    step(1'b0, 1'b1, 3, "R4");
    step(1'b1, 1'b1, 1, "R9");
    step(1'b1, 1'b0, 0, "R4");
    step(1'b1, 1'b0, 0, "R4");
    step(1'b0, 1'b1, 100, "R8");
    step(1'b1, 1'b0, 0, "R8");
    release_all("R9");

    // R5: fullest bank, ties to lowest bank
    psel_drv = 2;
    step(1'b0, 1'b0, 0, "R10");
    step(1'b1, 1'b0, 0, "R5");
    repeat (35) step(1'b1, 1'b0, 0, "R5");
    for (int i = 0; i < 15; i++) step(1'b0, 1'b1, i, "R5");
    step(1'b0, 1'b1, 20, "R5");
    step(1'b1, 1'b0, 0, "R5");
    step(1'b1, 1'b0, 0, "R5");
    for (int i = 32; i < 37; i++) step(1'b0, 1'b1, i, "R5");
    step(1'b1, 1'b0, 0, "R5");
    step(1'b1, 1'b0, 0, "R5");
    release_all("R9");

    // R6: recent bank with fallback
    psel_drv = 3;
    step(1'b0, 1'b0, 0, "R10");
    repeat (17) step(1'b1, 1'b0, 0, "R6");
    step(1'b0, 1'b1, 3, "R6");
    step(1'b1, 1'b0, 0, "R6");
    step(1'b0, 1'b1, 16, "R6");
    step(1'b0, 1'b1, 17, "R6");
    step(1'b1, 1'b0, 0, "R6");
    step(1'b1, 1'b0, 0, "R6");
    release_all("R9");

    // R10: back to queue order rebuilds ascending order
    psel_drv = 0;
    step(1'b0, 1'b0, 0, "R10");
    step(1'b1, 1'b0, 0, "R10");
    step(1'b1, 1'b0, 0, "R10");
    step(1'b1, 1'b0, 0, "R3");

    @(negedge clk);
    finish_up();
  end

endmodule